// File: doc/BRIEF.md
# Serializer loopback datapath controller

This block is the digital datapath of a 4-bit serializer/deserializer pair with two remote loopback points. On the receive side a 1-bit serial stream is shifted into 4-bit words, and each finished word comes with a one-cycle word strobe. That strobe is the receive bit clock divided by 4. On the transmit side an 8-word FIFO buffers 4-bit words, and a serializer turns them back into a 1-bit stream. Every clock is modelled as an enable pulse on a single fast clock: `rx_bit_en` is the recovered receive bit clock and `tx_bit_en` is the local transmit bit clock.

In serial loopback each received bit is retimed straight onto the transmit output. The transmit side then follows the receive bit clock, and the receive parallel output keeps working. In parallel loopback the deserialized words replace the external transmit words as the FIFO write source, so the received data is retransmitted through the FIFO and the serializer.

Each time parallel loopback is entered or left, the FIFO is flushed with a synchronous FIFO reset input. After that flush the serializer sends zeros until the FIFO has held two words. This keeps a safe distance between the read and write pointers.

Top module: `serdes_loop_ctrl`

## Requirements
- R1: While `ser_loop` is 1, every `rx_bit_en` cycle loads `rx_bit` into `tx_bit`, and the new value is visible from the next cycle.
- R2: While `ser_loop` is 1, `tx_bit` changes only on `rx_bit_en` cycles. Pulses on `tx_bit_en` and the FIFO contents have no effect on it.
- R3: The deserializer keeps running in every mode. The first bit of each group of four lands in `rx_word[3]` and the last lands in `rx_word[0]`.
- R4: `rx_word_stb` is high for exactly the one cycle after every fourth `rx_bit_en`, and `rx_word` holds the new word in that cycle.
- R5: With both loopbacks off, `tx_word_en` writes `tx_word` into the FIFO. The serializer sends one bit per `tx_bit_en`, bit 3 first, and sends the words in the order they were written.
- R6: While `par_loop` is 1, each receive word is written into the FIFO on its strobe cycle, and `tx_word_en` is ignored. The words come back out on `tx_bit` in the order they were received.
- R7: When `ser_loop` and `par_loop` are both 1, `tx_bit` follows serial loopback as in R1.
- R8: The FIFO holds 8 words. A write while it holds 8 words is dropped, and `fifo_ovf` goes to 1 and stays there until `fifo_clr`.
- R9: Once primed, if the serializer reaches a word boundary while the FIFO is empty, it sends a zero word, and `fifo_udf` goes to 1 and stays there until `fifo_clr`.
- R10: `fifo_clr` empties the FIFO, clears both flags, and returns the serializer to bit 3 of a zero word. After that the serializer sends zero words until the FIFO has held at least two words. Data then starts at the next word boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast simulation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit_en | input | 1 | Receive bit clock enable |
| rx_bit | input | 1 | Receive serial data |
| tx_bit_en | input | 1 | Local transmit bit clock enable |
| tx_word | input | 4 | External transmit parallel word |
| tx_word_en | input | 1 | Write strobe for `tx_word` |
| ser_loop | input | 1 | Serial remote loopback select |
| par_loop | input | 1 | Parallel remote loopback select |
| fifo_clr | input | 1 | Synchronous FIFO reset |
| tx_bit | output | 1 | Transmit serial data |
| rx_word | output | 4 | Receive parallel word |
| rx_word_stb | output | 1 | Receive word strobe (bit clock divided by 4) |
| fifo_ovf | output | 1 | Sticky FIFO overflow flag |
| fifo_udf | output | 1 | Sticky FIFO underflow flag |

## Verification
The bound checker watches several rules on every cycle:
- serial loopback forwarding and its immunity to the transmit enable;
- the single-cycle word strobe;
- the FIFO fill limit and the stickiness of both flags;
- the effect of a FIFO reset;
- the all-zero output before the FIFO is primed.

Data ordering cannot be seen cycle by cycle, so only the bench scenarios show it. These scenarios cover bit-3-first framing through the FIFO, retransmission of received words in parallel loopback, dropping of the ninth write, and the exact word boundary where real data follows the priming zeros.

// File: rtl/serdes_loop_pkg.sv
package serdes_loop_pkg;

  typedef enum logic [1:0] {
    PATH_LOCAL    = 2'd0,
    PATH_PARALLEL = 2'd1,
    PATH_SERIAL   = 2'd2
  } loop_path_e;

  // Serial loopback wins over parallel loopback for the transmit output.
  function automatic loop_path_e pick_path(input logic ser, input logic par);
    if (ser)      return PATH_SERIAL;
    else if (par) return PATH_PARALLEL;
    else          return PATH_LOCAL;
  endfunction

  // Serializer is primed once the FIFO fill reaches the threshold.
  function automatic logic fill_reached(input int unsigned fill, input int unsigned thr);
    return fill >= thr;
  endfunction

endpackage

// File: rtl/slc_deser.sv
module slc_deser #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         bit_in,
  output logic [W-1:0] word,
  output logic         word_stb
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  shreg;
  logic [CW-1:0] pos;
  logic          at_last;

  assign at_last = bit_en && (pos == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      pos      <= '0;
      word     <= '0;
      word_stb <= 1'b0;
    end else begin
      word_stb <= at_last;
      if (bit_en) begin
        shreg <= {shreg[W-2:0], bit_in};
        pos   <= at_last ? '0 : pos + 1'b1;
        if (at_last) word <= {shreg[W-2:0], bit_in};
      end
    end
  end
endmodule

// File: rtl/slc_fifo.sv
module slc_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd,
  input  logic          udf_evt,
  output logic [W-1:0]  rdata,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic          ovf,
  output logic          udf
);
  localparam int AW = $clog2(DEPTH);
  localparam int FW = $clog2(DEPTH + 1);
  localparam logic [FW-1:0] FULL = FW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push;

  assign push  = wr && (fill != FULL);
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; fill <= '0; ovf <= 1'b0; udf <= 1'b0;
    end else if (clr) begin
      wptr <= '0; rptr <= '0; fill <= '0; ovf <= 1'b0; udf <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (rd)   rptr <= rptr + 1'b1;
      case ({push, rd})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (wr && !push) ovf <= 1'b1;
      if (udf_evt)     udf <= 1'b1;
    end
  end
endmodule

// File: rtl/slc_ser.sv
module slc_ser
  import serdes_loop_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 8,
  parameter int PRIME = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [$clog2(DEPTH+1)-1:0] fill,
  input  logic [W-1:0] word_in,
  output logic         pop,
  output logic         underrun,
  output logic         bit_out,
  output logic         primed
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  cur;
  logic [CW-1:0] idx;
  logic          boundary;

  assign boundary = step && (idx == LAST);
  assign pop      = boundary && primed && (fill != '0);
  assign underrun = boundary && primed && (fill == '0);
  assign bit_out  = cur[W - 1 - int'(idx)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0; idx <= '0; primed <= 1'b0;
    end else if (clr) begin
      cur <= '0; idx <= '0; primed <= 1'b0;
    end else begin
      if (fill_reached(int'(fill), PRIME)) primed <= 1'b1;
      if (step) idx <= boundary ? '0 : idx + 1'b1;
      if (boundary) cur <= pop ? word_in : '0;
    end
  end
endmodule

// File: rtl/serdes_loop_ctrl.sv
module serdes_loop_ctrl
  import serdes_loop_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 8,
  parameter int PRIME = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_bit_en,
  input  logic         rx_bit,
  input  logic         tx_bit_en,
  input  logic [W-1:0] tx_word,
  input  logic         tx_word_en,
  input  logic         ser_loop,
  input  logic         par_loop,
  input  logic         fifo_clr,
  output logic         tx_bit,
  output logic [W-1:0] rx_word,
  output logic         rx_word_stb,
  output logic         fifo_ovf,
  output logic         fifo_udf
);
  localparam int FW = $clog2(DEPTH + 1);

  // Named internal events, brought out for the checker.
  loop_path_e      path;
  logic            serial_sel;
  logic            fifo_wr;
  logic [W-1:0]    fifo_wdata;
  logic [W-1:0]    fifo_rdata;
  logic [FW-1:0]   fifo_fill;
  logic            ser_pop;
  logic            ser_underrun;
  logic            ser_bit;
  logic            ser_primed;

  assign path       = pick_path(ser_loop, par_loop);
  assign serial_sel = (path == PATH_SERIAL);
  assign fifo_wr    = par_loop ? rx_word_stb : tx_word_en;
  assign fifo_wdata = par_loop ? rx_word : tx_word;

  slc_deser #(.W(W)) u_deser (
    .clk(clk), .rst_n(rst_n), .bit_en(rx_bit_en), .bit_in(rx_bit),
    .word(rx_word), .word_stb(rx_word_stb)
  );

  slc_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .wr(fifo_wr), .wdata(fifo_wdata),
    .rd(ser_pop), .udf_evt(ser_underrun), .rdata(fifo_rdata), .fill(fifo_fill),
    .ovf(fifo_ovf), .udf(fifo_udf)
  );

  slc_ser #(.W(W), .DEPTH(DEPTH), .PRIME(PRIME)) u_ser (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .step(tx_bit_en && !serial_sel),
    .fill(fifo_fill), .word_in(fifo_rdata), .pop(ser_pop),
    .underrun(ser_underrun), .bit_out(ser_bit), .primed(ser_primed)
  );

  // Output retimer: receive bit clock in serial loopback, local clock otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      tx_bit <= 1'b0;
    else if (serial_sel && rx_bit_en) tx_bit <= rx_bit;
    else if (!serial_sel && tx_bit_en) tx_bit <= ser_bit;
  end
endmodule

// File: rtl/serdes_loop_ctrl_chk.sv
module serdes_loop_ctrl_chk #(
  parameter int DEPTH = 8,
  parameter int FW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ser_loop,
  input logic          rx_bit_en,
  input logic          rx_bit,
  input logic          tx_bit_en,
  input logic          tx_bit,
  input logic          rx_word_stb,
  input logic          fifo_clr,
  input logic          fifo_ovf,
  input logic          fifo_udf,
  input logic [FW-1:0] fifo_fill,
  input logic          ser_primed
);
  localparam logic [FW-1:0] FULL = FW'(DEPTH);

  assert_serial_forward_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_loop && rx_bit_en) |=> (tx_bit == $past(rx_bit)));

  assert_serial_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_loop && !rx_bit_en) |=> $stable(tx_bit));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_stb |=> !rx_word_stb);

  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_fill <= FULL);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ovf && !fifo_clr) |=> fifo_ovf);

  assert_udf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_udf && !fifo_clr) |=> fifo_udf);

  assert_clear_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (fifo_fill == '0 && !fifo_ovf && !fifo_udf && !ser_primed));

  assert_unprimed_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_primed && !ser_loop && tx_bit_en) |=> !tx_bit);
endmodule

bind serdes_loop_ctrl serdes_loop_ctrl_chk #(.DEPTH(DEPTH), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_loop(ser_loop), .rx_bit_en(rx_bit_en),
  .rx_bit(rx_bit), .tx_bit_en(tx_bit_en), .tx_bit(tx_bit),
  .rx_word_stb(rx_word_stb), .fifo_clr(fifo_clr), .fifo_ovf(fifo_ovf),
  .fifo_udf(fifo_udf), .fifo_fill(fifo_fill), .ser_primed(ser_primed)
);

// File: tb/sim_serdes_loop_ctrl.sv
`timescale 1ns/1ps
module sim_serdes_loop_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit_en = 0, rx_bit = 0, tx_bit_en = 0, tx_word_en = 0;
  logic ser_loop = 0, par_loop = 0, fifo_clr = 0;
  logic [3:0] tx_word = '0;
  logic tx_bit, rx_word_stb, fifo_ovf, fifo_udf;
  logic [3:0] rx_word;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serdes_loop_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rx_bit_en(rx_bit_en), .rx_bit(rx_bit),
    .tx_bit_en(tx_bit_en), .tx_word(tx_word), .tx_word_en(tx_word_en),
    .ser_loop(ser_loop), .par_loop(par_loop), .fifo_clr(fifo_clr),
    .tx_bit(tx_bit), .rx_word(rx_word), .rx_word_stb(rx_word_stb),
    .fifo_ovf(fifo_ovf), .fifo_udf(fifo_udf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rx_one(input logic b);
    @(negedge clk); rx_bit = b; rx_bit_en = 1'b1;
    @(negedge clk); rx_bit_en = 1'b0;
  endtask

  // Sends a word bit 3 first; optionally checks the serial loopback echo.
  task automatic rx_send(input logic [3:0] w, input bit echo, input string req);
    for (int i = 3; i >= 0; i--) begin
      rx_one(w[i]);
      if (echo) check(tx_bit == w[i], req, tx_bit, w[i]);
      if (i == 1) check(rx_word_stb == 1'b0, "R4 strobe early", rx_word_stb, 0);
    end
    check(rx_word == w, "R3 word order", rx_word, w);
    check(rx_word_stb == 1'b1, "R4 strobe", rx_word_stb, 1);
  endtask

  task automatic tx_one(output logic b);
    @(negedge clk); tx_bit_en = 1'b1;
    @(negedge clk); tx_bit_en = 1'b0;
    b = tx_bit;
  endtask

  task automatic tx_expect(input logic [3:0] exp, input string req);
    logic [3:0] got;
    logic b;
    for (int i = 3; i >= 0; i--) begin
      tx_one(b);
      got[i] = b;
    end
    check(got == exp, req, got, exp);
  endtask

  task automatic ext_write(input logic [3:0] w);
    @(negedge clk); tx_word = w; tx_word_en = 1'b1;
    @(negedge clk); tx_word_en = 1'b0;
  endtask

  task automatic clear_fifo();
    @(negedge clk); fifo_clr = 1'b1;
    @(negedge clk); fifo_clr = 1'b0;
  endtask

  task automatic t_reset();
    check(tx_bit == 0, "R10 reset tx_bit", tx_bit, 0);
    check(rx_word == 0, "R3 reset rx_word", rx_word, 0);
    check(rx_word_stb == 0, "R4 reset strobe", rx_word_stb, 0);
    check({fifo_ovf, fifo_udf} == 0, "R8 R9 reset flags", {fifo_ovf, fifo_udf}, 0);
  endtask

  task automatic t_deser();
    rx_send(4'hA, 0, "R3");
    rx_send(4'h5, 0, "R3");
    @(negedge clk);
    check(rx_word_stb == 0, "R4 strobe one cycle", rx_word_stb, 0);
  endtask

  task automatic t_local_tx();
    clear_fifo();
    ext_write(4'hA); ext_write(4'h3); ext_write(4'hC);
    tx_expect(4'h0, "R10 priming zeros");
    tx_expect(4'hA, "R5 first word");
    tx_expect(4'h3, "R5 second word");
    check(fifo_udf == 0, "R9 no underflow yet", fifo_udf, 0);
    tx_expect(4'hC, "R5 third word");
    check(fifo_udf == 1, "R9 underflow at boundary", fifo_udf, 1);
    tx_expect(4'h0, "R9 zero word on underflow");
    check(fifo_udf == 1, "R9 flag sticky", fifo_udf, 1);
  endtask

  task automatic t_priming();
    clear_fifo();
    check(fifo_udf == 0, "R10 clear udf", fifo_udf, 0);
    ext_write(4'h7);
    tx_expect(4'h0, "R10 one word held");
    tx_expect(4'h0, "R10 still unprimed");
    check(fifo_udf == 0, "R10 no underflow unprimed", fifo_udf, 0);
    ext_write(4'h2);
    tx_expect(4'h0, "R10 zeros until boundary");
    tx_expect(4'h7, "R10 first data after priming");
    tx_expect(4'h2, "R5 order after priming");
  endtask

  task automatic t_overflow();
    clear_fifo();
    for (int i = 1; i <= 8; i++) ext_write(4'(i));
    check(fifo_ovf == 0, "R8 eight words fit", fifo_ovf, 0);
    ext_write(4'h9);
    check(fifo_ovf == 1, "R8 ninth write overflows", fifo_ovf, 1);
    tx_expect(4'h0, "R10 zeros before boundary");
    tx_expect(4'h1, "R8 oldest word kept");
    tx_expect(4'h2, "R8 order kept");
    check(fifo_ovf == 1, "R8 flag sticky", fifo_ovf, 1);
    clear_fifo();
    check({fifo_ovf, fifo_udf} == 0, "R10 flags cleared", {fifo_ovf, fifo_udf}, 0);
    ext_write(4'hD); ext_write(4'hE);
    tx_expect(4'h0, "R10 pointers reset zeros");
    tx_expect(4'hD, "R10 pointers reset first");
    tx_expect(4'hE, "R10 pointers reset second");
  endtask

  task automatic t_serial();
    logic b;
    ser_loop = 1'b1;
    rx_send(4'h6, 1, "R1 serial echo");
    rx_send(4'hB, 1, "R1 serial echo");
    ext_write(4'h0);
    tx_one(b);
    check(b == 1'b1, "R2 tx_bit_en ignored", b, 1);
    tx_one(b);
    check(b == 1'b1, "R2 tx_bit_en ignored again", b, 1);
  endtask

  task automatic t_priority();
    par_loop = 1'b1;
    rx_send(4'h9, 1, "R7 serial wins");
    rx_send(4'h4, 1, "R7 serial wins");
    @(negedge clk); ser_loop = 1'b0;
  endtask

  task automatic t_parallel();
    clear_fifo();
    rx_send(4'h3, 0, "R6");
    ext_write(4'hF);
    rx_send(4'h9, 0, "R6");
    ext_write(4'hF);
    rx_send(4'h6, 0, "R6");
    @(negedge clk);
    tx_expect(4'h0, "R10 priming in parallel loopback");
    tx_expect(4'h3, "R6 retransmit first");
    tx_expect(4'h9, "R6 retransmit second");
    tx_expect(4'h6, "R6 retransmit third");
    tx_expect(4'h0, "R6 external writes ignored");
    @(negedge clk); par_loop = 1'b0;
    clear_fifo();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_deser();
    t_local_tx();
    t_priming();
    t_overflow();
    t_serial();
    t_priority();
    t_parallel();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule